// File: doc/BRIEF.md
# Byte-wide command port slave

The block sits between a host processor's 8-bit bus and a peripheral controller's execution engine. The host writes a header byte to the data address. Its upper nibble selects one of nine operations, and its lower nibble says how many operand bytes follow. The port stores the operands in a holding register. Once the last operand arrives, it hands the complete command to the engine with a one-cycle valid pulse. The ready output stays low until the engine reports completion. The engine's result byte is then posted in an output register for the host to read.

The host reads a status byte at the second address to follow this exchange. The status byte carries the output-buffer-full, input-buffer-full, overflow and ready flags. A header whose type code is not defined is rejected on the spot with an error result. Any write that arrives while a command is executing is dropped and leaves a sticky overflow mark.

Host strobes are taken as synchronous, one clock per access. A write takes priority over a read in the same cycle.

Top module: `cmd_port_slave`

## Requirements
- R1: After reset, ready_o is 1, cmd_valid_o is 0 and the status byte reads 0x08.
- R2: In a header byte, bits 7:4 are the command type and bits 3:0 are the operand count. At dispatch, cmd_type_o and cmd_len_o carry these two fields.
- R3: A valid header with count 0 dispatches at once. cmd_valid_o is high in the cycle after the write, and ready_o is low from that cycle on.
- R4: With count n>0, the next n data writes are stored in order, operand i at operands_o[8i+7:8i]. Dispatch follows the n-th write, and ready_o stays 1 while operands are being collected.
- R5: ready_o stays low from dispatch until done_i is sampled high. A done_i pulse while no command is executing has no effect.
- R6: When done_i ends execution, result_i is captured into the result register, output-buffer-full is set and ready_o returns to 1 in the next cycle.
- R7: The valid type codes are 1 to 9, in this order: put character and advance pointer, put at address, display control, clear display, show menu, keyboard command, keyboard read, serial send, serial receive. Codes 0 and 10 to 15 never dispatch. ready_o stays 1, the result becomes 0xEE, output-buffer-full is set, and the count nibble is ignored.
- R8: A host write (either address) while ready_o is low is dropped and sets a sticky overflow flag, which only reset clears.
- R9: The status byte at address 1 is {4'b0, ready, overflow, input-buffer-full, output-buffer-full}, from bit 7 down to bit 0. Reading it changes nothing.
- R10: A read at address 0 returns the result register and clears output-buffer-full. If completion arrives in the same cycle, the flag ends up set.
- R11: Input-buffer-full is 1 from the accepted valid header until execution completes.
- R12: cmd_valid_o is high for exactly one cycle per dispatched command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Host chip select |
| wr_i | input | 1 | Host write strobe, one cycle |
| rd_i | input | 1 | Host read strobe, one cycle |
| addr_i | input | 1 | 0 selects data/result, 1 selects status |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, combinational on addr_i |
| ready_o | output | 1 | Low while a command executes |
| cmd_valid_o | output | 1 | One-cycle dispatch pulse to the engine |
| cmd_type_o | output | 4 | Type of the dispatched command |
| cmd_len_o | output | 4 | Operand count of the dispatched command |
| operands_o | output | 120 | Operand holding register, slot i in bits 8i+7:8i |
| done_i | input | 1 | Engine completion pulse |
| result_i | input | 8 | Engine result, sampled with done_i |

## Verification
The bench aims at these corner cases:
- The zero-count header. A port that waits for an operand here would hang, and the watchdog would report it.
- The full fifteen-operand header. An off-by-one in the slot counter would either dispatch early or misplace the last byte.
- Undefined type codes 0 and 15. A port that accepts either one produces an unexpected dispatch, which the scoreboard flags.
- A completion in the same cycle as a result read, which exposes a wrong set/clear priority on output-buffer-full.
- Writes during execution. A port that does not drop them either dispatches a phantom command or leaves the overflow bit clear.
- A stray done_i while the port is idle. A port that accepts it corrupts the result register.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_EXEC    = 2'd2
  } pcp_state_e;

  // valid command type range
  localparam int CMD_FIRST = 1;
  localparam int CMD_LAST  = 9;

  // status byte bit positions
  localparam int STAT_OBF = 0;
  localparam int STAT_IBF = 1;
  localparam int STAT_OVF = 2;
  localparam int STAT_RDY = 3;
endpackage

// File: rtl/pcp_host_if.sv
module pcp_host_if #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              addr_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic [DATA_W-1:0] status_i,
  output logic              wr_data_o,
  output logic              wr_blocked_o,
  output logic              rd_data_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic wr_any;

  assign wr_any       = cs_i & wr_i;
  assign wr_data_o    = wr_any & ~addr_i & ~busy_i;
  assign wr_blocked_o = wr_any & busy_i;
  // write wins over a simultaneous read
  assign rd_data_o    = cs_i & rd_i & ~wr_i & ~addr_i;
  assign rdata_o      = addr_i ? status_i : result_i;
endmodule

// File: rtl/pcp_collector.sv
module pcp_collector import pcp_pkg::*; #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned MAX_OPS = 15
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [DATA_W-1:0]         byte_i,
  input  logic                      done_i,
  output logic                      busy_o,
  output logic                      collecting_o,
  output logic                      err_o,
  output logic                      done_ok_o,
  output logic                      cmd_valid_o,
  output logic [DATA_W-CNT_W-1:0]   cmd_type_o,
  output logic [CNT_W-1:0]          cmd_len_o,
  output logic [MAX_OPS*DATA_W-1:0] operands_o
);
  localparam int unsigned TYPE_W = DATA_W - CNT_W;

  pcp_state_e         state_q;
  logic [TYPE_W-1:0]  type_q;
  logic [CNT_W-1:0]   len_q;
  logic [CNT_W-1:0]   idx_q;
  logic               valid_q;
  logic [TYPE_W-1:0]  hdr_type;
  logic [CNT_W-1:0]   hdr_len;
  logic               hdr_known;
  logic               hdr_take;
  logic               op_take;
  logic               last_op;

  assign hdr_type  = byte_i[DATA_W-1 -: TYPE_W];
  assign hdr_len   = byte_i[CNT_W-1:0];
  assign hdr_known = (int'(hdr_type) >= CMD_FIRST) && (int'(hdr_type) <= CMD_LAST);
  assign hdr_take  = wr_i && (state_q == ST_IDLE);
  assign op_take   = wr_i && (state_q == ST_COLLECT);
  assign last_op   = (idx_q == len_q - 1'b1);

  assign busy_o       = (state_q == ST_EXEC);
  assign collecting_o = (state_q == ST_COLLECT);
  assign err_o        = hdr_take && !hdr_known;
  assign done_ok_o    = done_i && (state_q == ST_EXEC);
  assign cmd_valid_o  = valid_q;
  assign cmd_type_o   = type_q;
  assign cmd_len_o    = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      type_q  <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (hdr_take && hdr_known) begin
            type_q <= hdr_type;
            len_q  <= hdr_len;
            idx_q  <= '0;
            if (hdr_len == '0) begin
              state_q <= ST_EXEC;
              valid_q <= 1'b1;
            end else begin
              state_q <= ST_COLLECT;
            end
          end
        end
        ST_COLLECT: begin
          if (op_take) begin
            idx_q <= idx_q + 1'b1;
            if (last_op) begin
              state_q <= ST_EXEC;
              valid_q <= 1'b1;
            end
          end
        end
        ST_EXEC: begin
          if (done_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < MAX_OPS; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  slot_q <= '0;
      else if (op_take && idx_q == CNT_W'(g))       slot_q <= byte_i;
    end
    assign operands_o[g*DATA_W +: DATA_W] = slot_q;
  end
endmodule

// File: rtl/pcp_result.sv
module pcp_result #(
  parameter int unsigned      DATA_W  = 8,
  parameter logic [DATA_W-1:0] ERR_VAL = 8'hEE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              rd_i,
  input  logic              blocked_i,
  output logic [DATA_W-1:0] res_o,
  output logic              obf_o,
  output logic              ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      obf_o <= 1'b0;
      ovf_o <= 1'b0;
    end else begin
      if (err_i)       res_o <= ERR_VAL;
      else if (done_i) res_o <= result_i;
      // posting beats a same-cycle read
      if (err_i || done_i) obf_o <= 1'b1;
      else if (rd_i)       obf_o <= 1'b0;
      if (blocked_i)       ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/cmd_port_slave.sv
module cmd_port_slave import pcp_pkg::*; #(
  parameter int unsigned       DATA_W  = 8,
  parameter int unsigned       CNT_W   = 4,
  parameter int unsigned       MAX_OPS = (1 << CNT_W) - 1,
  parameter logic [DATA_W-1:0] ERR_VAL = 8'hEE
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cs_i,
  input  logic                      wr_i,
  input  logic                      rd_i,
  input  logic                      addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      ready_o,
  output logic                      cmd_valid_o,
  output logic [DATA_W-CNT_W-1:0]   cmd_type_o,
  output logic [CNT_W-1:0]          cmd_len_o,
  output logic [MAX_OPS*DATA_W-1:0] operands_o,
  input  logic                      done_i,
  input  logic [DATA_W-1:0]         result_i
);
  logic              busy, collecting, err_ev, done_ok;
  logic              wr_data, wr_blocked, rd_data;
  logic [DATA_W-1:0] res_q, status;
  logic              obf_q, ovf_q, ibf;

  assign ready_o = ~busy;
  assign ibf     = collecting | busy;

  always_comb begin
    status           = '0;
    status[STAT_OBF] = obf_q;
    status[STAT_IBF] = ibf;
    status[STAT_OVF] = ovf_q;
    status[STAT_RDY] = ready_o;
  end

  pcp_host_if #(.DATA_W(DATA_W)) u_host (
    .cs_i        (cs_i),
    .wr_i        (wr_i),
    .rd_i        (rd_i),
    .addr_i      (addr_i),
    .busy_i      (busy),
    .result_i    (res_q),
    .status_i    (status),
    .wr_data_o   (wr_data),
    .wr_blocked_o(wr_blocked),
    .rd_data_o   (rd_data),
    .rdata_o     (rdata_o)
  );

  pcp_collector #(.DATA_W(DATA_W), .CNT_W(CNT_W), .MAX_OPS(MAX_OPS)) u_coll (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_data),
    .byte_i      (wdata_i),
    .done_i      (done_i),
    .busy_o      (busy),
    .collecting_o(collecting),
    .err_o       (err_ev),
    .done_ok_o   (done_ok),
    .cmd_valid_o (cmd_valid_o),
    .cmd_type_o  (cmd_type_o),
    .cmd_len_o   (cmd_len_o),
    .operands_o  (operands_o)
  );

  pcp_result #(.DATA_W(DATA_W), .ERR_VAL(ERR_VAL)) u_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .err_i    (err_ev),
    .done_i   (done_ok),
    .result_i (result_i),
    .rd_i     (rd_data),
    .blocked_i(wr_blocked),
    .res_o    (res_q),
    .obf_o    (obf_q),
    .ovf_o    (ovf_q)
  );
endmodule

// File: rtl/pcp_chk.sv
module pcp_chk import pcp_pkg::*; #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cs_i,
  input logic                    wr_i,
  input logic                    ready_o,
  input logic                    cmd_valid_o,
  input logic [DATA_W-CNT_W-1:0] cmd_type_o,
  input logic                    done_i,
  input logic [DATA_W-1:0]       result_i,
  input logic [DATA_W-1:0]       res_q,
  input logic                    obf_q,
  input logic                    ovf_q
);
  // R3
  dispatch_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !ready_o);

  // R12
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  // R5
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !done_i) |=> !ready_o);

  // R6
  completion_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && done_i) |=> (ready_o && obf_q && res_q == $past(result_i)));

  // R7
  known_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (int'(cmd_type_o) >= CMD_FIRST && int'(cmd_type_o) <= CMD_LAST));

  // R8
  overflow_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && !ready_o) |=> ovf_q);

  // R8
  overflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
endmodule

bind cmd_port_slave pcp_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_pcp_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_i       (cs_i),
  .wr_i       (wr_i),
  .ready_o    (ready_o),
  .cmd_valid_o(cmd_valid_o),
  .cmd_type_o (cmd_type_o),
  .done_i     (done_i),
  .result_i   (result_i),
  .res_q      (res_q),
  .obf_q      (obf_q),
  .ovf_q      (ovf_q)
);

// File: tb/test_cmd_port_slave.sv
module test_cmd_port_slave;
  localparam int CLK_PERIOD = 10;
  localparam int NOPS       = 15;

  typedef struct packed {
    logic [3:0]        t;
    logic [3:0]        n;
    logic [NOPS*8-1:0] ops;
  } exp_cmd_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cs = 1'b0, wr = 1'b0, rd = 1'b0, addr = 1'b0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic              ready, cmd_valid;
  logic [3:0]        cmd_type, cmd_len;
  logic [NOPS*8-1:0] operands;
  logic              done = 1'b0;
  logic [7:0]        result = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  exp_cmd_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_port_slave i_cmd_port_slave (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready), .cmd_valid_o(cmd_valid),
    .cmd_type_o(cmd_type), .cmd_len_o(cmd_len), .operands_o(operands),
    .done_i(done), .result_i(result)
  );

  function automatic logic [7:0] st(bit obf, bit ibf, bit ovf, bit rdy);
    return {4'b0, rdy, ovf, ibf, obf};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(logic a, logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic host_rd(logic a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic engine_done(logic [7:0] r);
    @(negedge clk); done = 1; result = r;
    @(negedge clk); done = 0;
  endtask

  // driver: push expected dispatch, then issue header and operands
  task automatic send_cmd(logic [7:0] hdr, logic [NOPS*8-1:0] ops);
    exp_cmd_t e;
    e.t = hdr[7:4]; e.n = hdr[3:0]; e.ops = ops;
    exp_q.push_back(e);
    host_wr(1'b0, hdr);
    for (int i = 0; i < int'(hdr[3:0]); i++) host_wr(1'b0, ops[i*8 +: 8]);
  endtask

  // monitor: compare every dispatch against the scoreboard
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      exp_cmd_t e;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R7/R8 unexpected dispatch actual=%h expected=none", {cmd_type, cmd_len});
      end else begin
        e = exp_q.pop_front();
        if ({cmd_type, cmd_len} !== {e.t, e.n}) begin
          fails++;
          $display("FAIL R2 header actual=%h expected=%h", {cmd_type, cmd_len}, {e.t, e.n});
        end else begin
          for (int i = 0; i < NOPS; i++) begin
            if (i < int'(e.n) && operands[i*8 +: 8] !== e.ops[i*8 +: 8]) begin
              fails++;
              $display("FAIL R4 slot %0d actual=%h expected=%h", i,
                       operands[i*8 +: 8], e.ops[i*8 +: 8]);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R5 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]        d;
    logic [NOPS*8-1:0] big;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready", {7'b0, ready}, 8'h01);
    chk("R1 valid", {7'b0, cmd_valid}, 8'h00);
    host_rd(1'b1, d); chk("R1 status", d, st(0, 0, 0, 1));

    // R3 zero-count dispatch, R11 ibf during exec
    send_cmd(8'h30, '0);
    chk("R3 ready low", {7'b0, ready}, 8'h00);
    host_rd(1'b1, d); chk("R11 status in exec", d, st(0, 1, 0, 0));
    repeat (3) @(negedge clk);
    chk("R5 still busy", {7'b0, ready}, 8'h00);
    engine_done(8'h5A);
    chk("R6 ready back", {7'b0, ready}, 8'h01);
    host_rd(1'b1, d); chk("R9 status obf", d, st(1, 0, 0, 1));
    host_rd(1'b1, d); chk("R9 status read no clear", d, st(1, 0, 0, 1));
    host_rd(1'b0, d); chk("R10 data", d, 8'h5A);
    host_rd(1'b1, d); chk("R10 obf cleared", d, st(0, 0, 0, 1));

    // R4 three operands
    host_wr(1'b0, 8'h13);
    exp_q.push_back('{t: 4'h1, n: 4'h3, ops: {{(NOPS-3)*8{1'b0}}, 24'h332211}});
    chk("R4 ready while collecting", {7'b0, ready}, 8'h01);
    host_rd(1'b1, d); chk("R11 ibf collecting", d, st(0, 1, 0, 1));
    host_wr(1'b0, 8'h11);
    host_wr(1'b0, 8'h22);
    chk("R4 no early dispatch", {7'b0, ready}, 8'h01);
    host_wr(1'b0, 8'h33);
    chk("R4 dispatched", {7'b0, ready}, 8'h00);
    engine_done(8'hA1);
    host_rd(1'b0, d); chk("R6 result", d, 8'hA1);

    // R5 stray done while idle
    engine_done(8'h77);
    host_rd(1'b1, d); chk("R5 idle done status", d, st(0, 0, 0, 1));
    host_rd(1'b0, d); chk("R5 idle done result", d, 8'hA1);

    // R7 undefined codes
    host_wr(1'b0, 8'hF2);
    chk("R7 ready F", {7'b0, ready}, 8'h01);
    host_rd(1'b1, d); chk("R7 status F", d, st(1, 0, 0, 1));
    host_rd(1'b0, d); chk("R7 err F", d, 8'hEE);
    host_wr(1'b0, 8'h05);
    host_rd(1'b1, d); chk("R7 status 0", d, st(1, 0, 0, 1));
    host_rd(1'b0, d); chk("R7 err 0", d, 8'hEE);

    // R4 maximum count
    big = '0;
    for (int i = 0; i < NOPS; i++) big[i*8 +: 8] = 8'(i * 7 + 1);
    exp_q.push_back('{t: 4'h7, n: 4'hF, ops: big});
    host_wr(1'b0, 8'h7F);
    for (int i = 0; i < NOPS - 1; i++) host_wr(1'b0, big[i*8 +: 8]);
    chk("R4 ready before last", {7'b0, ready}, 8'h01);
    host_wr(1'b0, big[(NOPS-1)*8 +: 8]);
    chk("R4 ready after last", {7'b0, ready}, 8'h00);
    engine_done(8'hC3);
    host_rd(1'b0, d); chk("R6 max result", d, 8'hC3);

    // R10 completion and read in the same cycle
    send_cmd(8'h90, '0);
    @(negedge clk); done = 1; result = 8'h3C; cs = 1; rd = 1; addr = 0;
    @(negedge clk); done = 0; cs = 0; rd = 0;
    host_rd(1'b1, d); chk("R10 set beats clear", d, st(1, 0, 0, 1));
    host_rd(1'b0, d); chk("R10 new result", d, 8'h3C);

    // R8 writes while busy
    send_cmd(8'h20, '0);
    host_wr(1'b0, 8'h41);
    host_wr(1'b1, 8'h55);
    chk("R8 still busy", {7'b0, ready}, 8'h00);
    host_rd(1'b1, d); chk("R8 ovf set", d, st(0, 1, 1, 0));
    engine_done(8'h99);
    repeat (3) @(negedge clk);
    host_rd(1'b1, d); chk("R8 after done", d, st(1, 0, 1, 1));
    host_rd(1'b0, d); chk("R8 result", d, 8'h99);
    host_rd(1'b1, d); chk("R8 sticky", d, st(0, 0, 1, 1));

    repeat (4) @(negedge clk);
    chk("R12 scoreboard drained", 8'(exp_q.size()), 8'h00);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule